// File: doc/BRIEF.md
# Connectivity Test Chain and Mode Controller

This block gives board test equipment a way to prove that a set of input pins is soldered and connected. A test-enable pin is sampled as the part leaves its power-on reset. If that pin is high, the part enters test mode. In test mode the included input pins are chained through two-input NAND stages, and the chain result is driven out on the shared address pin.

The tester first drives every chained input high, which sets the output high. It then pulls the inputs low one after another in chain order. Each step flips the output, so a pin that never moves the output is open or shorted.

The first serial-bus start condition ends test mode. After that the address pin returns to its normal job as an input for the core. Test mode cannot come back until the next power-on reset, whatever the test-enable pin does in the meantime.

Top module: `nandTreeCtl`

## Requirements
- R1: While `porRstN` is low, `testActive` and `addrPadOe` are 0.
- R2: On the first rising clock edge after `porRstN` goes high, `testActive` takes the value of `testEnPin`.
- R3: Once that first edge has passed, changes on `testEnPin` have no effect on `testActive`.
- R4: A `busStart` pulse while test mode is active clears `testActive` on the next edge. It then stays 0 until the next power-on reset.
- R5: If `busStart` is high on the capture edge, test mode is not entered, even with `testEnPin` high.
- R6: In test mode with every bit of `chainIn` at 1, `addrPadOut` is 1.
- R7: In test mode, bit 0 of `chainIn` is the first pin in test order (bus data) and the top bit is the last (reset). `addrPadOut` is 1 when all bits are 1. Otherwise it is 1 exactly when the highest-index bit at 0 has an odd index.
- R8: In test mode, pulling bits low in order starting at bit 0, with each step adding one more low bit, flips `addrPadOut` at every step.
- R9: When test mode is active, `addrPadOe` is 1 and `coreAddr` is 0. When it is inactive, `addrPadOe` and `addrPadOut` are 0 and `coreAddr` equals `addrPadIn`.
- R10: A new power-on reset with `testEnPin` high re-enters test mode, even after a bus access ended the previous session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| testEnPin | input | 1 | Test-enable pin, sampled once at reset release |
| busStart | input | 1 | One-cycle strobe for a serial-bus start condition |
| chainIn | input | NUM_CHAIN | Chained input pins, bit 0 first in test order |
| addrPadIn | input | 1 | Value received on the shared address pin |
| addrPadOut | output | 1 | Chain result driven toward the address pin |
| addrPadOe | output | 1 | Output enable for the address pin |
| coreAddr | output | 1 | Address bit delivered to the core |
| testActive | output | 1 | Test mode is active |

## Verification
The bench builds the block with `NUM_CHAIN` set to 5. At that width every one of the 32 input patterns can be swept, and the expected output for each is worked out from the index of the highest low bit. An odd chain length also exercises the generate branch that adds the final inversion. Several power-on cycles are run: with the test-enable pin high, with it low, and with a bus start on the capture edge. Together these cover entry, the blocked entry, exit, and re-entry after a fresh power-up.

// File: rtl/nandTreePkg.sv
package nandTreePkg;
  // strobes from the mode controller to the chain datapath
  typedef struct packed {
    logic chainEn;   // let the chain result reach the pad
    logic padDrive;  // turn the shared address pin into an output
  } modeStrobe_t;
endpackage

// File: rtl/nandTreeMode.sv
module nandTreeMode
  import nandTreePkg::*;
(
  input  logic        clk,
  input  logic        porRstN,
  input  logic        testEnPin,
  input  logic        busStart,
  output modeStrobe_t strobes,
  output logic        testActive
);
  logic captured;
  logic modeFlag;
  logic busSeen;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      captured <= 1'b0;
      modeFlag <= 1'b0;
      busSeen  <= 1'b0;
    end else begin
      if (busStart) busSeen <= 1'b1;
      if (!captured) begin
        captured <= 1'b1;
        modeFlag <= testEnPin & ~busStart;
      end
    end
  end

  // the sticky bus flag overrides the power-up sample for good
  assign testActive       = modeFlag & ~busSeen;
  assign strobes.chainEn  = testActive;
  assign strobes.padDrive = testActive;
endmodule

// File: rtl/nandTreeChain.sv
module nandTreeChain
  import nandTreePkg::*;
#(
  parameter int NUM_CHAIN = 8
) (
  input  logic [NUM_CHAIN-1:0] chainIn,
  input  logic                 addrPadIn,
  input  modeStrobe_t          strobes,
  output logic                 addrPadOut,
  output logic                 addrPadOe,
  output logic                 coreAddr
);
  localparam int LAST_STAGE = NUM_CHAIN - 1;
  localparam bit ODD_LENGTH = (NUM_CHAIN % 2) == 1;

  logic [NUM_CHAIN-1:0] stageOut;
  logic                 chainOut;

  assign stageOut[0] = ~(chainIn[0] & 1'b1);

  genvar s;
  generate
    for (s = 1; s < NUM_CHAIN; s++) begin : g_stage
      assign stageOut[s] = ~(chainIn[s] & stageOut[s-1]);
    end
    if (ODD_LENGTH) begin : g_fixOdd
      // an odd count of stages would leave the all-high result low
      assign chainOut = ~stageOut[LAST_STAGE];
    end else begin : g_evenPass
      assign chainOut = stageOut[LAST_STAGE];
    end
  endgenerate

  assign addrPadOut = strobes.chainEn & chainOut;
  assign addrPadOe  = strobes.padDrive;
  assign coreAddr   = strobes.padDrive ? 1'b0 : addrPadIn;
endmodule

// File: rtl/nandTreeCtl.sv
module nandTreeCtl
  import nandTreePkg::*;
#(
  parameter int NUM_CHAIN = 8
) (
  input  logic                 clk,
  input  logic                 porRstN,
  input  logic                 testEnPin,
  input  logic                 busStart,
  input  logic [NUM_CHAIN-1:0] chainIn,
  input  logic                 addrPadIn,
  output logic                 addrPadOut,
  output logic                 addrPadOe,
  output logic                 coreAddr,
  output logic                 testActive
);
  modeStrobe_t strobes;

  nandTreeMode u_mode (
    .clk       (clk),
    .porRstN   (porRstN),
    .testEnPin (testEnPin),
    .busStart  (busStart),
    .strobes   (strobes),
    .testActive(testActive)
  );

  nandTreeChain #(.NUM_CHAIN(NUM_CHAIN)) u_chain (
    .chainIn   (chainIn),
    .addrPadIn (addrPadIn),
    .strobes   (strobes),
    .addrPadOut(addrPadOut),
    .addrPadOe (addrPadOe),
    .coreAddr  (coreAddr)
  );
endmodule

// File: rtl/nandTreeCtlChk.sv
module nandTreeCtlChk #(
  parameter int NUM_CHAIN = 8
) (
  input logic                 clk,
  input logic                 porRstN,
  input logic                 busStart,
  input logic [NUM_CHAIN-1:0] chainIn,
  input logic                 addrPadIn,
  input logic                 addrPadOut,
  input logic                 addrPadOe,
  input logic                 coreAddr,
  input logic                 testActive
);
  logic [1:0] edgesSinceRst;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) edgesSinceRst <= 2'd0;
    else if (edgesSinceRst != 2'd3) edgesSinceRst <= edgesSinceRst + 2'd1;
  end

  always @(posedge clk) begin
    if (!porRstN) begin
      AST_RESET_IDLE: assert (!testActive && !addrPadOe); // R1
    end
  end

  AST_BUS_EXITS: assert property (@(posedge clk) disable iff (!porRstN)
    busStart |=> !testActive); // R4

  AST_NO_LATE_ENTRY: assert property (@(posedge clk) disable iff (!porRstN)
    (edgesSinceRst >= 2'd2) && !$past(testActive) |-> !testActive); // R3

  AST_OE_TRACKS_MODE: assert property (@(posedge clk) disable iff (!porRstN)
    addrPadOe == testActive); // R9

  AST_CORE_ADDR_PASS: assert property (@(posedge clk) disable iff (!porRstN)
    !testActive |-> (coreAddr == addrPadIn) && !addrPadOut); // R9

  AST_ALL_HIGH_OUT: assert property (@(posedge clk) disable iff (!porRstN)
    testActive && (&chainIn) |-> addrPadOut); // R6
endmodule

bind nandTreeCtl nandTreeCtlChk #(.NUM_CHAIN(NUM_CHAIN)) u_chk (
  .clk       (clk),
  .porRstN   (porRstN),
  .busStart  (busStart),
  .chainIn   (chainIn),
  .addrPadIn (addrPadIn),
  .addrPadOut(addrPadOut),
  .addrPadOe (addrPadOe),
  .coreAddr  (coreAddr),
  .testActive(testActive)
);

// File: tb/nandTreeCtl_tb.sv
module nandTreeCtl_tb;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         porRstN = 1'b0;
  logic         testEnPin = 1'b0;
  logic         busStart = 1'b0;
  logic [N-1:0] chainIn = '1;
  logic         addrPadIn = 1'b0;
  logic         addrPadOut, addrPadOe, coreAddr, testActive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  nandTreeCtl #(.NUM_CHAIN(N)) u_dut (
    .clk(clk), .porRstN(porRstN), .testEnPin(testEnPin), .busStart(busStart),
    .chainIn(chainIn), .addrPadIn(addrPadIn), .addrPadOut(addrPadOut),
    .addrPadOe(addrPadOe), .coreAddr(coreAddr), .testActive(testActive)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // 1 if all high, else 1 when the highest low index is odd
  function automatic logic expectOut(input logic [N-1:0] p);
    int hi = -1;
    for (int i = 0; i < N; i++) if (!p[i]) hi = i;
    return (hi < 0) ? 1'b1 : logic'(hi % 2);
  endfunction

  task automatic powerUp(input logic en, input logic bus);
    @(negedge clk);
    porRstN = 1'b0;
    busStart = 1'b0;
    @(negedge clk);
    check("R1 active in reset", testActive, 1'b0);
    check("R1 oe in reset", addrPadOe, 1'b0);
    testEnPin = en;
    busStart  = bus;
    porRstN   = 1'b1;
    @(negedge clk);
    busStart = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    powerUp(1'b1, 1'b0);
    check("R2 entry with pin high", testActive, 1'b1);
    testEnPin = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 pin change ignored", testActive, 1'b1);

    for (int p = 0; p < (1 << N); p++) begin
      chainIn = p[N-1:0];
      addrPadIn = p[0];
      @(negedge clk);
      check("R7 pattern sweep", addrPadOut, expectOut(p[N-1:0]));
      if (p == (1 << N) - 1) check("R6 all high", addrPadOut, 1'b1);
      check("R9 oe in test", addrPadOe, 1'b1);
      check("R9 core addr masked", coreAddr, 1'b0);
    end

    for (int m = 0; m <= N; m++) begin
      chainIn = '1;
      for (int b = 0; b < m; b++) chainIn[b] = 1'b0;
      @(negedge clk);
      check("R8 ordered toggle", addrPadOut, (m % 2) == 0);
    end

    busStart = 1'b1;
    @(negedge clk);
    busStart = 1'b0;
    check("R4 exit on bus start", testActive, 1'b0);
    testEnPin = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 stays out", testActive, 1'b0);
    chainIn = '1;
    addrPadIn = 1'b1;
    @(negedge clk);
    check("R9 oe off", addrPadOe, 1'b0);
    check("R9 out off", addrPadOut, 1'b0);
    check("R9 core addr high", coreAddr, 1'b1);
    addrPadIn = 1'b0;
    @(negedge clk);
    check("R9 core addr low", coreAddr, 1'b0);

    powerUp(1'b0, 1'b0);
    check("R2 no entry with pin low", testActive, 1'b0);
    testEnPin = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 late pin high ignored", testActive, 1'b0);

    powerUp(1'b1, 1'b1);
    check("R5 bus on capture edge", testActive, 1'b0);

    powerUp(1'b1, 1'b0);
    check("R10 re-entry after power cycle", testActive, 1'b1);
    check("R9 oe back on", addrPadOe, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule